// File: doc/BRIEF.md
# Protection table miss refill engine

This block keeps a table of sixteen protection descriptors, each a page start address paired with a 32-bit attribute word. When an instruction fetch misses in the table, the surrounding logic pulses `start` with the faulting address. The engine then picks an entry to evict and closes the gap by moving every later entry down one slot. It then walks a configuration ROM of address/data pairs and writes the first pair that covers the address into the top slot. Protection checking is switched off while the table is being rewritten.

A fault that already lands inside a valid installed page comes from a fetch that runs across the end of that page. In that case the search uses the fault address plus a fixed step, so that the following page is loaded. The outcome is returned as a two-bit status on a one-cycle `done` pulse. The table is visible to the checking logic through a combinational read port.

Top module: `ptab_refill`

## Requirements
- R1: After reset `busy` and `done` are low, `prot_en` is high and every table entry reads as start 0, data 0 (invalid).
- R2: `start` is taken only while `busy` is low. `busy` is high from the next cycle until the cycle in which `done` is high for exactly one cycle, and `busy` is low in that cycle. A `start` seen while `busy` is high has no effect.
- R3: The status carried with `done` is 0 for reloaded, 1 for no unlocked entry and 2 for no address match. The value 3 never appears.
- R4: In a data word, bit 0 is valid, bit 1 is locked and bits 17:16 give the page size (0 = 1 KB, 1 = 4 KB, 2 = 1 MB, 3 = 4 MB). An address is covered when start <= address < start + size, compared unsigned, so the first byte past the page is not covered.
- R5: Configuration pair k has its address word at ROM word 2k and its data word at 2k+1, each read with one cycle of latency. Pairs are examined from k = 0 upward, and the first covering pair is installed into entry 15. An address word of all ones ends the table.
- R6: The victim is the lowest-index entry that is invalid or not locked. Each entry above it takes the contents of its upper neighbour, and entry 15 receives the new descriptor.
- R7: When all 16 entries are valid and locked, the status is 1 with `done` two cycles after `start` is taken, and the table is left unchanged.
- R8: When no pair covers the address, the status is 2. The compaction has already happened, so entry 15 keeps its previous contents, which then also appear one slot lower.
- R9: If the fault address is covered by a valid installed entry, the search uses the fault address plus 64. Otherwise the search uses the fault address itself.
- R10: `prot_en` goes low in the cycle after `start` is taken. It goes high again together with `done` only for status 0, and stays low after a failed refill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Refill request pulse |
| fault_addr | input | 32 | Address that missed |
| busy | output | 1 | Refill in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Outcome, valid with `done` |
| prot_en | output | 1 | Protection checking enable |
| rom_addr | output | 6 | Configuration ROM word address |
| rom_rdata | input | 32 | Configuration ROM word, one cycle after `rom_addr` |
| rd_idx | input | 4 | Table entry to observe |
| rd_start | output | 32 | Page start of entry `rd_idx` |
| rd_data | output | 32 | Data word of entry `rd_idx` |

## Verification
The bench builds the block with its defaults: 16 entries, a 6-bit ROM address holding up to 32 pairs, and a 64-byte step. Sixteen refills therefore fill the table, which brings the victim-above-zero case and the all-locked case within reach in a few hundred cycles. A 64-byte step inside a 1 KB page makes it possible to show the next page being chosen by a fault near the top of a page. Ten ROM pairs cover every page size, an upper bound that is exclusive, two overlapping pages to test first-match order, and the end marker.

// File: rtl/ptab_pkg.sv
package ptab_pkg;

    localparam int unsigned PT_WORD_W   = 32;
    localparam int unsigned PT_VALID_BIT = 0;
    localparam int unsigned PT_LOCK_BIT  = 1;
    localparam int unsigned PT_SIZE_LSB  = 16;

    typedef logic [PT_WORD_W-1:0] word_t;

    typedef struct packed {
        word_t start;
        word_t data;
    } pt_entry_t;

    typedef enum logic [1:0] {
        PT_RELOADED   = 2'd0,
        PT_ALL_LOCKED = 2'd1,
        PT_NO_MATCH   = 2'd2
    } pt_status_e;

    localparam word_t PT_END_MARK = '1;

    // Byte length of a page for its 2-bit size code.
    function automatic logic [PT_WORD_W:0] pt_page_bytes(input logic [1:0] code);
        logic [PT_WORD_W:0] len;
        case (code)
            2'd0:    len = (PT_WORD_W+1)'(32'h0000_0400);
            2'd1:    len = (PT_WORD_W+1)'(32'h0000_1000);
            2'd2:    len = (PT_WORD_W+1)'(32'h0010_0000);
            default: len = (PT_WORD_W+1)'(32'h0040_0000);
        endcase
        return len;
    endfunction

    // Unsigned half-open range test; end computed one bit wider.
    function automatic logic pt_covers(input word_t start, input word_t data, input word_t addr);
        logic [PT_WORD_W:0] last_ex;
        last_ex = {1'b0, start} + pt_page_bytes(data[PT_SIZE_LSB +: 2]);
        return (start <= addr) && ({1'b0, addr} < last_ex);
    endfunction

endpackage

// File: rtl/ptab_victim_pick.sv
module ptab_victim_pick
    import ptab_pkg::*;
#(
    parameter int unsigned N_ENT = 16,
    parameter int unsigned IDX_W = $clog2(N_ENT)
) (
    input  pt_entry_t [N_ENT-1:0] ents,
    input  word_t                 addr,
    output logic                  any_hit,
    output logic                  found,
    output logic [IDX_W-1:0]      idx
);

    logic [N_ENT-1:0] evictable;
    logic [N_ENT-1:0] covering;

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        assign evictable[g] = !ents[g].data[PT_VALID_BIT] || !ents[g].data[PT_LOCK_BIT];
        assign covering[g]  = ents[g].data[PT_VALID_BIT] &&
                              pt_covers(ents[g].start, ents[g].data, addr);
    end

    // Lowest index wins: walk downward so the last write is the smallest.
    always_comb begin
        found   = |evictable;
        any_hit = |covering;
        idx     = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (evictable[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ptab_store.sv
module ptab_store
    import ptab_pkg::*;
#(
    parameter int unsigned N_ENT = 16,
    parameter int unsigned IDX_W = $clog2(N_ENT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_en,
    input  logic [IDX_W-1:0]      shift_from,
    input  logic                  ins_en,
    input  pt_entry_t             ins_entry,
    output pt_entry_t [N_ENT-1:0] ents
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ents <= '0;
        end else begin
            // Entries at and above the victim slide down one slot.
            for (int i = 0; i < N_ENT - 1; i++) begin
                if (shift_en && (i >= int'(shift_from))) ents[i] <= ents[i+1];
            end
            // The top slot is written only by an install; a shift leaves it as is.
            if (ins_en) ents[N_ENT-1] <= ins_entry;
        end
    end

endmodule

// File: rtl/ptab_refill.sv
module ptab_refill
    import ptab_pkg::*;
#(
    parameter int unsigned N_ENT      = 16,
    parameter int unsigned ROM_AW     = 6,
    parameter int unsigned CROSS_STEP = 64,
    localparam int unsigned IDX_W     = $clog2(N_ENT),
    localparam int unsigned PTR_W     = ROM_AW - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [31:0]       fault_addr,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              prot_en,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [31:0]       rom_rdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [31:0]       rd_start,
    output logic [31:0]       rd_data
);

    typedef enum logic [2:0] {
        S_IDLE,   // waiting for a request
        S_PICK,   // choose victim, compact, fix search address
        S_RA,     // issue ROM read of address word
        S_RD,     // address word returns; issue data word read
        S_EV      // data word returns; range test and install
    } fsm_e;

    fsm_e              state_q;
    word_t             fault_q;
    word_t             search_q;
    word_t             cand_start_q;
    logic [PTR_W-1:0]  ptr_q;
    logic              done_q;
    pt_status_e        status_q;
    logic              prot_q;

    pt_entry_t [N_ENT-1:0] ents;
    logic                  any_hit;
    logic                  vic_found;
    logic [IDX_W-1:0]      vic_idx;
    logic                  shift_en;
    logic                  ins_en;
    logic                  cand_cover;
    pt_entry_t             ins_entry;

    ptab_victim_pick #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_pick (
        .ents    (ents),
        .addr    (fault_q),
        .any_hit (any_hit),
        .found   (vic_found),
        .idx     (vic_idx)
    );

    ptab_store #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (shift_en),
        .shift_from (vic_idx),
        .ins_en     (ins_en),
        .ins_entry  (ins_entry),
        .ents       (ents)
    );

    assign cand_cover = pt_covers(cand_start_q, rom_rdata, search_q);
    assign shift_en   = (state_q == S_PICK) && vic_found;
    assign ins_en     = (state_q == S_EV) && cand_cover;
    assign ins_entry  = '{start: cand_start_q, data: rom_rdata};

    always_comb begin
        case (state_q)
            S_RA:    rom_addr = {ptr_q, 1'b0};
            S_RD:    rom_addr = {ptr_q, 1'b1};
            default: rom_addr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            fault_q      <= '0;
            search_q     <= '0;
            cand_start_q <= '0;
            ptr_q        <= '0;
            done_q       <= 1'b0;
            status_q     <= PT_RELOADED;
            prot_q       <= 1'b1;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        fault_q <= fault_addr;
                        prot_q  <= 1'b0;
                        state_q <= S_PICK;
                    end
                end
                S_PICK: begin
                    if (!vic_found) begin
                        done_q   <= 1'b1;
                        status_q <= PT_ALL_LOCKED;
                        state_q  <= S_IDLE;
                    end else begin
                        search_q <= any_hit ? (fault_q + word_t'(CROSS_STEP)) : fault_q;
                        ptr_q    <= '0;
                        state_q  <= S_RA;
                    end
                end
                S_RA: begin
                    state_q <= S_RD;
                end
                S_RD: begin
                    if (rom_rdata == PT_END_MARK) begin
                        done_q   <= 1'b1;
                        status_q <= PT_NO_MATCH;
                        state_q  <= S_IDLE;
                    end else begin
                        cand_start_q <= rom_rdata;
                        state_q      <= S_EV;
                    end
                end
                S_EV: begin
                    if (cand_cover) begin
                        done_q   <= 1'b1;
                        status_q <= PT_RELOADED;
                        prot_q   <= 1'b1;
                        state_q  <= S_IDLE;
                    end else begin
                        ptr_q   <= ptr_q + PTR_W'(1);
                        state_q <= S_RA;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != S_IDLE);
    assign done     = done_q;
    assign status   = status_q;
    assign prot_en  = prot_q;
    assign rd_start = ents[rd_idx].start;
    assign rd_data  = ents[rd_idx].data;

endmodule

// File: rtl/ptab_refill_chk.sv
module ptab_refill_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [1:0] status,
    input logic       prot_en
);

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_at_done_R2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    assert_status_legal_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (status != 2'd3));

    assert_prot_off_busy_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> !prot_en);

    assert_prot_on_ok_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(prot_en) |-> (done && status == 2'd0));

endmodule

bind ptab_refill ptab_refill_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .status  (status),
    .prot_en (prot_en)
);

// File: tb/ptab_refill_bench.sv
`timescale 1ns/1ps
module ptab_refill_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] fault_addr = '0;
    logic        busy, done, prot_en;
    logic [1:0]  status;
    logic [5:0]  rom_addr;
    logic [31:0] rom_rdata = '0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_start, rd_data;

    logic [31:0] rom [64];

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;   // 4 ns period

    always @(posedge clk) rom_rdata <= rom[rom_addr];

    ptab_refill u_ptab_refill (
        .clk(clk), .rst(rst), .start(start), .fault_addr(fault_addr),
        .busy(busy), .done(done), .status(status), .prot_en(prot_en),
        .rom_addr(rom_addr), .rom_rdata(rom_rdata),
        .rd_idx(rd_idx), .rd_start(rd_start), .rd_data(rd_data)
    );

    // Descriptor data words used below
    localparam logic [31:0] D_1K   = 32'h0000_0001;
    localparam logic [31:0] D_4K   = 32'h0001_0001;
    localparam logic [31:0] D_1M   = 32'h0002_0001;
    localparam logic [31:0] D_4M   = 32'h0003_0001;
    localparam logic [31:0] D_4K_L = 32'h0001_0003;
    localparam logic [31:0] D_MARK = 32'h0000_0005;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_entry(input int idx, input logic [31:0] es, input logic [31:0] ed, input string tag);
        rd_idx = 4'(idx);
        #1;
        check(rd_start === es && rd_data === ed, tag, {rd_start, rd_data}, {es, ed});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic refill(input logic [31:0] fa, input bit poke,
                          output logic [1:0] st, output int cyc);
        @(negedge clk);
        start = 1'b1; fault_addr = fa;
        @(negedge clk);
        start = 1'b0; cyc = 1;
        check(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        check(prot_en === 1'b0, "R10 prot off after start", 64'(prot_en), 64'd0);
        if (poke) begin
            start = 1'b1; fault_addr = 32'h0000_9000;
            @(negedge clk);
            start = 1'b0; cyc++;
        end
        while (!done && cyc < 4000) begin
            @(negedge clk);
            cyc++;
        end
        check(done === 1'b1, "R2 done reached", 64'(done), 64'd1);
        check(busy === 1'b0, "R2 busy low with done", 64'(busy), 64'd0);
        st = status;
    endtask

    task automatic t_reset();
        do_reset();
        check(busy === 1'b0 && done === 1'b0, "R1 idle after reset", {busy, done}, 2'b00);
        check(prot_en === 1'b1, "R1 prot on after reset", 64'(prot_en), 64'd1);
        for (int i = 0; i < 16; i++) chk_entry(i, 32'h0, 32'h0, "R1 entry cleared");
    endtask

    task automatic t_basic();
        logic [1:0] st; int cyc; bit quiet;
        do_reset();
        refill(32'h0000_1234, 1'b1, st, cyc);
        check(st === 2'd0, "R3 reloaded code", 64'(st), 64'd0);
        check(prot_en === 1'b1, "R10 prot back on", 64'(prot_en), 64'd1);
        chk_entry(15, 32'h0000_1000, D_1K, "R5 installed in top slot");
        chk_entry(14, 32'h0, 32'h0, "R6 lower slots still invalid");
        quiet = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (busy || done) quiet = 1'b0;
        end
        check(quiet, "R2 start while busy ignored", 64'(quiet), 64'd1);
    endtask

    task automatic t_bounds();
        logic [1:0] st; int cyc;
        do_reset();
        refill(32'h0000_1400, 1'b0, st, cyc);
        check(st === 2'd0, "R4 status at 1K edge", 64'(st), 64'd0);
        chk_entry(15, 32'h0000_1400, D_1K, "R4 upper bound exclusive");
        refill(32'h0000_8FFF, 1'b0, st, cyc);
        chk_entry(15, 32'h0000_8000, D_4K, "R4 last byte of 4K page");
        refill(32'h001F_FFFF, 1'b0, st, cyc);
        chk_entry(15, 32'h0010_0000, D_1M, "R4 last byte of 1M page");
        chk_entry(14, 32'h0000_8000, D_4K, "R6 earlier install moved down");
        refill(32'h0050_0010, 1'b0, st, cyc);
        chk_entry(15, 32'h0040_0000, D_4M, "R5 first covering pair wins");
    endtask

    task automatic t_nomatch();
        logic [1:0] st; int cyc;
        do_reset();
        refill(32'h0000_1234, 1'b0, st, cyc);
        refill(32'h0000_9000, 1'b0, st, cyc);
        check(st === 2'd2, "R8 no match code", 64'(st), 64'd2);
        check(prot_en === 1'b0, "R10 prot stays off after failure", 64'(prot_en), 64'd0);
        chk_entry(15, 32'h0000_1000, D_1K, "R8 top slot kept");
        chk_entry(14, 32'h0000_1000, D_1K, "R8 compaction applied");
        chk_entry(13, 32'h0, 32'h0, "R8 below untouched invalid");
    endtask

    task automatic t_advance();
        logic [1:0] st; int cyc;
        do_reset();
        refill(32'h0000_13F0, 1'b0, st, cyc);
        chk_entry(15, 32'h0000_1000, D_1K, "R9 no step without hit");
        refill(32'h0000_13F0, 1'b0, st, cyc);
        check(st === 2'd0, "R9 status after step", 64'(st), 64'd0);
        chk_entry(15, 32'h0000_1400, D_1K, "R9 stepped into next page");
        chk_entry(14, 32'h0000_1000, D_1K, "R9 previous page moved down");
    endtask

    task automatic t_victim_locked();
        logic [1:0] st; int cyc; bit all_ok;
        do_reset();
        all_ok = 1'b1;
        for (int i = 0; i < 14; i++) begin
            refill(32'h0002_0000, 1'b0, st, cyc);
            if (st !== 2'd0) all_ok = 1'b0;
        end
        check(all_ok, "R6 locked fills reloaded", 64'(all_ok), 64'd1);
        refill(32'h0003_0000, 1'b0, st, cyc);
        refill(32'h0004_0000, 1'b0, st, cyc);
        chk_entry(14, 32'h0003_0000, D_4K, "R6 unlocked entry placed");
        refill(32'h0005_0000, 1'b0, st, cyc);
        check(st === 2'd0, "R6 evict unlocked", 64'(st), 64'd0);
        chk_entry(13, 32'h0002_0000, D_4K_L, "R6 locked below victim kept");
        chk_entry(14, 32'h0004_0000, D_4K_L, "R6 slot above victim shifted");
        chk_entry(15, 32'h0005_0000, D_4K_L, "R6 new entry at top");
        chk_entry(0, 32'h0002_0000, D_4K_L, "R6 bottom entry kept");
        refill(32'h0000_1234, 1'b0, st, cyc);
        check(st === 2'd1, "R7 all locked code", 64'(st), 64'd1);
        check(cyc == 2, "R7 latency two cycles", 64'(cyc), 64'd2);
        check(prot_en === 1'b0, "R10 prot off after all locked", 64'(prot_en), 64'd0);
        chk_entry(15, 32'h0005_0000, D_4K_L, "R7 table unchanged top");
        chk_entry(14, 32'h0004_0000, D_4K_L, "R7 table unchanged next");
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) rom[i] = 32'hFFFF_FFFF;
        rom[0]  = 32'h0000_1000; rom[1]  = D_1K;
        rom[2]  = 32'h0000_1400; rom[3]  = D_1K;
        rom[4]  = 32'h0010_0000; rom[5]  = D_1M;
        rom[6]  = 32'h0040_0000; rom[7]  = D_4M;
        rom[8]  = 32'h0050_0000; rom[9]  = D_MARK;
        rom[10] = 32'h0002_0000; rom[11] = D_4K_L;
        rom[12] = 32'h0003_0000; rom[13] = D_4K;
        rom[14] = 32'h0004_0000; rom[15] = D_4K_L;
        rom[16] = 32'h0005_0000; rom[17] = D_4K_L;
        rom[18] = 32'h0000_8000; rom[19] = D_4K;
        t_reset();
        t_basic();
        t_bounds();
        t_nomatch();
        t_advance();
        t_victim_locked();
        summary();
        $finish;
    end

endmodule